// File: doc/BRIEF.md
# Receive-Path End-of-Frame Status Logic

This block gathers eight sticky event and fail flags for one receive path. Each flag comes from a single-cycle detector pulse: carrier fail, amplitude fail, symbol-timing fail, Manchester fail, timeout, frame length reached, signal-strength range, or the other path's end-of-frame. A condition-select register picks which flags may raise the path's end-of-frame interrupt. The interrupt is sticky and stays high until software writes to it or the path is disabled.

Software drives the block through write strobes for the status, condition-select and interrupt registers, which share one data bus. A path-enable input clears all state. When the hardware-managed mode input is high, the status register cannot be written. In that mode, every rising edge of the interrupt toggles a pointer bit and clears the status flags one cycle later, ready for the next frame.

Top module: `rx_eof_status`

## Requirements
- R1: After a synchronous active-low reset, `stat_o`, `cond_o`, `irq_o` and `ptr_o` are all 0.
- R2: A pulse on `evt_i[i]` while `path_en_i` is 1 sets `stat_o[i]` at the next clock edge, and the bit stays set until a clear source acts. Bit meanings: 0 carrier fail, 1 amplitude fail, 2 symbol timing fail, 3 Manchester fail, 4 timeout, 5 frame length reached, 6 signal-strength range, 7 other path end-of-frame.
- R3: `irq_o` rises at the same clock edge that sets a status bit whose `cond_o` bit is 1. An event on a bit whose `cond_o` bit is 0 leaves `irq_o` at 0.
- R4: Outside hardware-managed mode, `wr_stat_i` clears each status bit whose `wdata_i` bit is 1. Status bits whose `wdata_i` bit is 0 keep their value.
- R5: `wr_irq_i` with `wdata_i[0]`=1 clears `irq_o` and every status bit. With `wdata_i[0]`=0, the write has no effect.
- R6: `wr_cond_i` loads `cond_o` from `wdata_i`. It clears every status bit only when the new value differs from the current `cond_o`.
- R7: While `path_en_i` is 0, `stat_o` and `irq_o` are 0 from the next edge on, and event pulses are ignored.
- R8: When a set event and a clear source act on a bit in the same cycle, the bit ends up set. A new enabled event likewise keeps `irq_o` set against an interrupt clear write.
- R9: While `hw_mode_i` is 1, `wr_stat_i` writes have no effect on `stat_o`.
- R10: While `hw_mode_i` is 1, `ptr_o` toggles exactly once at each rising edge of `irq_o`, even when several enabled events fire in one cycle. All status bits are cleared at the following edge. `ptr_o` does not change at any other time.
- R11: A pulse on either `tmo_wake_i` or `tmo_sof_i` sets status bit 4, the timeout bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| path_en_i | input | 1 | Receive path enable; 0 clears flags and interrupt |
| hw_mode_i | input | 1 | Hardware-managed receive mode |
| evt_i | input | 8 | Single-cycle detector event pulses, one per status bit |
| tmo_wake_i | input | 1 | Timeout pulse from the wake-check search |
| tmo_sof_i | input | 1 | Timeout pulse from the start-of-frame search |
| wr_stat_i | input | 1 | Status register write strobe (write 1 to clear) |
| wr_cond_i | input | 1 | Condition-select register write strobe |
| wr_irq_i | input | 1 | Interrupt flag write strobe (bit 0 = 1 clears) |
| wdata_i | input | 8 | Shared write data |
| stat_o | output | 8 | Status flags |
| cond_o | output | 8 | Condition-select register |
| irq_o | output | 1 | Path end-of-frame interrupt flag |
| ptr_o | output | 1 | Pointer bit toggled in hardware-managed mode |

## Verification
The main function is driven in four ways:
- Single events on enabled and on masked bits show that the interrupt gate follows the condition mask and not just any flag.
- Both timeout sources and the other-path pulse confirm the bit mapping.
- Each clear source is applied on its own, and next to a set event in the same cycle, which separates the clear paths from one another and checks the set-wins priority.
- In hardware-managed mode, several enabled events in one cycle, an event while the interrupt is already high, and a fresh event after clearing the interrupt show that the pointer follows interrupt edges and not event counts.

// File: rtl/rx_eof_pkg.sv
// Package: shared constants for the receive-path end-of-frame status block.
// Assumes an 8-bit register width; bit positions are fixed by the status map.
package rx_eof_pkg;
    localparam int FLAG_W   = 8;
    localparam int BIT_CAR  = 0;
    localparam int BIT_AMP  = 1;
    localparam int BIT_SYM  = 2;
    localparam int BIT_MAN  = 3;
    localparam int BIT_TMO  = 4;
    localparam int BIT_LEN  = 5;
    localparam int BIT_RSS  = 6;
    localparam int BIT_OTH  = 7;
    localparam int IRQ_CLR_BIT = 0;
endpackage

// File: rtl/rx_eof_cond.sv
// Module: condition-select register.
// Loads on every write strobe and flags a write whose value differs from
// the stored one, so the status flags can be cleared.
module rx_eof_cond #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cond_o,
    output logic         chg_o
);
    logic [W-1:0] cond_q;

    // Flag a write that changes the stored mask.
    always_comb chg_o = wr_i && (wdata_i != cond_q);

    // Hold the mask; reload it on each write.
    always_ff @(posedge clk) begin
        if (!rst_n)    cond_q <= '0;
        else if (wr_i) cond_q <= wdata_i;
    end

    assign cond_o = cond_q;

    // R6
    cond_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (cond_o == $past(wdata_i)));
endmodule

// File: rtl/rx_eof_flags.sv
// Module: sticky status flags, one cell per bit.
// Assumes set_v is already masked by path enable. A set event outranks
// every clear source in the same cycle.
module rx_eof_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] sw_clr_v,
    input  logic         clr_all_i,
    input  logic         path_en_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // One sticky bit: set wins, then per-bit or global clear, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)                        stat_q[i] <= 1'b0;
            else if (set_v[i])                 stat_q[i] <= 1'b1;
            else if (clr_all_i || sw_clr_v[i]) stat_q[i] <= 1'b0;
        end
    end

    assign stat_o = stat_q;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((stat_o & $past(set_v)) == $past(set_v)));

    // R7
    path_off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !path_en_i |=> (stat_o == '0));

    // R4
    keep_unwritten_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all_i && set_v == '0) |=> ((stat_o & ~$past(sw_clr_v)) == ($past(stat_o) & ~$past(sw_clr_v))));
endmodule

// File: rtl/rx_eof_irq.sv
// Module: sticky end-of-frame interrupt with the hardware-mode pointer.
// A rising interrupt in hardware mode toggles the pointer and requests a
// status clear for the next cycle.
module rx_eof_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic path_en_i,
    input  logic hw_mode_i,
    input  logic hit_i,
    input  logic wr_clr_i,
    output logic irq_o,
    output logic ptr_o,
    output logic auto_clr_o
);
    logic irq_q, ptr_q, auto_q, rise;

    // Interrupt rises only from low with the path enabled.
    always_comb rise = path_en_i && hit_i && !irq_q;

    // Interrupt flag: disable clears, enabled hit sets, write-1 clears.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq_q <= 1'b0;
        else if (!path_en_i) irq_q <= 1'b0;
        else if (hit_i)      irq_q <= 1'b1;
        else if (wr_clr_i)   irq_q <= 1'b0;
    end

    // Pointer toggle and next-cycle auto clear in hardware mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= 1'b0;
            auto_q <= 1'b0;
        end else begin
            auto_q <= hw_mode_i && rise;
            if (hw_mode_i && rise) ptr_q <= ~ptr_q;
        end
    end

    assign irq_o      = irq_q;
    assign ptr_o      = ptr_q;
    assign auto_clr_o = auto_q;

    // R3
    hit_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (path_en_i && hit_i) |=> irq_o);

    // R10
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_mode_i && path_en_i && hit_i && !irq_o) |=> $stable(ptr_o));

    // R7
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !path_en_i |=> !irq_o);
endmodule

// File: rtl/rx_eof_status.sv
// Module: receive-path end-of-frame status block (top).
// Merges detector pulses into sticky flags, gates them through the
// condition mask into a sticky interrupt, and handles hardware-managed
// clearing. Assumes all pulses are synchronous to clk.
module rx_eof_status
    import rx_eof_pkg::*;
#(
    parameter int W = FLAG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         path_en_i,
    input  logic         hw_mode_i,
    input  logic [W-1:0] evt_i,
    input  logic         tmo_wake_i,
    input  logic         tmo_sof_i,
    input  logic         wr_stat_i,
    input  logic         wr_cond_i,
    input  logic         wr_irq_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] cond_o,
    output logic         irq_o,
    output logic         ptr_o
);
    logic [W-1:0] set_v, sw_clr_v, tmo_v;
    logic         cond_chg, irq_wr_clr, auto_clr, clr_all, hit;

    // Place the merged timeout pulse on its status bit.
    always_comb begin
        tmo_v = '0;
        tmo_v[BIT_TMO] = tmo_wake_i | tmo_sof_i;
    end

    // Gate set events by path enable; gate software clears by mode.
    always_comb begin
        set_v      = path_en_i ? (evt_i | tmo_v) : '0;
        sw_clr_v   = (wr_stat_i && !hw_mode_i) ? wdata_i : '0;
        irq_wr_clr = wr_irq_i && wdata_i[IRQ_CLR_BIT];
        clr_all    = !path_en_i || irq_wr_clr || cond_chg || auto_clr;
        hit        = |(set_v & cond_o);
    end

    rx_eof_cond #(.W(W)) u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_cond_i),
        .wdata_i (wdata_i),
        .cond_o  (cond_o),
        .chg_o   (cond_chg)
    );

    rx_eof_flags #(.W(W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_v     (set_v),
        .sw_clr_v  (sw_clr_v),
        .clr_all_i (clr_all),
        .path_en_i (path_en_i),
        .stat_o    (stat_o)
    );

    rx_eof_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .path_en_i  (path_en_i),
        .hw_mode_i  (hw_mode_i),
        .hit_i      (hit),
        .wr_clr_i   (irq_wr_clr),
        .irq_o      (irq_o),
        .ptr_o      (ptr_o),
        .auto_clr_o (auto_clr)
    );

    // R9
    hw_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_mode_i && path_en_i && !irq_wr_clr && !cond_chg && !auto_clr && set_v == '0)
        |=> (stat_o == $past(stat_o)));

    // R11
    tmo_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (path_en_i && (tmo_wake_i || tmo_sof_i)) |=> stat_o[BIT_TMO]);
endmodule

// File: tb/sim_rx_eof_status.sv
// Bench: directed scenarios, one task each, with self-checking counters.
module sim_rx_eof_status;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       path_en = 1'b0, hw_mode = 1'b0;
    logic [7:0] evt = '0;
    logic       tmo_wake = 1'b0, tmo_sof = 1'b0;
    logic       wr_stat = 1'b0, wr_cond = 1'b0, wr_irq = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] stat, cond;
    logic       irq, ptr;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    rx_eof_status u0 (
        .clk(clk), .rst_n(rst_n), .path_en_i(path_en), .hw_mode_i(hw_mode),
        .evt_i(evt), .tmo_wake_i(tmo_wake), .tmo_sof_i(tmo_sof),
        .wr_stat_i(wr_stat), .wr_cond_i(wr_cond), .wr_irq_i(wr_irq),
        .wdata_i(wdata), .stat_o(stat), .cond_o(cond), .irq_o(irq), .ptr_o(ptr)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic pulse(input logic [7:0] v);
        evt = v; cyc(); evt = '0;
    endtask

    task automatic wr_st(input logic [7:0] d);
        wdata = d; wr_stat = 1'b1; cyc(); wr_stat = 1'b0;
    endtask

    task automatic wr_cd(input logic [7:0] d);
        wdata = d; wr_cond = 1'b1; cyc(); wr_cond = 1'b0;
    endtask

    task automatic wr_iq(input logic [7:0] d);
        wdata = d; wr_irq = 1'b1; cyc(); wr_irq = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 stat", stat, 8'h00);
        check("R1 cond", cond, 8'h00);
        check("R1 irq/ptr", {6'd0, irq, ptr}, 8'h00);
    endtask

    task automatic t_sticky();
        pulse(8'h01);
        check("R2 carrier bit", stat, 8'h01);
        pulse(8'h80);
        cyc();
        check("R2 sticky plus other-path bit7", stat, 8'h81);
        check("R3 masked no irq", {7'd0, irq}, 8'h00);
        wr_iq(8'h01);
    endtask

    task automatic t_irq_mask();
        wr_cd(8'h08);
        pulse(8'h04);
        check("R3 masked bit no irq", {7'd0, irq}, 8'h00);
        pulse(8'h08);
        check("R3 enabled bit raises irq", {7'd0, irq}, 8'h01);
        check("R3 status", stat, 8'h0C);
        wr_iq(8'h00);
        check("R5 write0 irq kept", {7'd0, irq}, 8'h01);
        wr_iq(8'h01);
        check("R5 irq cleared", {7'd0, irq}, 8'h00);
        check("R5 status cleared", stat, 8'h00);
    endtask

    task automatic t_sw_clear();
        pulse(8'h62);
        wr_st(8'h40);
        check("R4 w1c one bit", stat, 8'h22);
        wr_st(8'h00);
        check("R4 write zero no effect", stat, 8'h22);
        wr_st(8'hFF);
    endtask

    task automatic t_cond_clear();
        pulse(8'h03);
        wr_cd(8'h08);
        check("R6 same value keeps", stat, 8'h03);
        wr_cd(8'h00);
        check("R6 new value clears", stat, 8'h00);
        check("R6 cond loaded", cond, 8'h00);
    endtask

    task automatic t_disable();
        wr_cd(8'h01);
        pulse(8'h11);
        check("R7 pre irq", {7'd0, irq}, 8'h01);
        path_en = 1'b0; cyc();
        check("R7 disable clears stat", stat, 8'h00);
        check("R7 disable clears irq", {7'd0, irq}, 8'h00);
        pulse(8'hFF);
        check("R7 events ignored", stat, 8'h00);
        path_en = 1'b1; cyc();
        wr_cd(8'h00);
    endtask

    task automatic t_set_wins();
        pulse(8'h10);
        evt = 8'h04; wdata = 8'h05; wr_irq = 1'b1; wr_stat = 1'b1;
        cyc();
        evt = '0; wr_irq = 1'b0; wr_stat = 1'b0;
        check("R8 set beats clears", stat, 8'h04);
        wr_cd(8'h02);
        pulse(8'h02);
        evt = 8'h02; wdata = 8'h01; wr_irq = 1'b1; cyc();
        evt = '0; wr_irq = 1'b0;
        check("R8 irq set beats clear", {7'd0, irq}, 8'h01);
        wr_iq(8'h01);
        wr_cd(8'h00);
    endtask

    task automatic t_timeout();
        tmo_wake = 1'b1; cyc(); tmo_wake = 1'b0;
        check("R11 wake timeout", stat, 8'h10);
        wr_st(8'h10);
        tmo_sof = 1'b1; cyc(); tmo_sof = 1'b0;
        check("R11 sof timeout", stat, 8'h10);
        wr_st(8'h10);
    endtask

    task automatic t_hw();
        hw_mode = 1'b1;
        pulse(8'h20);
        wr_st(8'h20);
        check("R9 write ignored", stat, 8'h20);
        wr_iq(8'h01);
        wr_cd(8'h03);
        pulse(8'h03);
        check("R10 ptr toggled once", {7'd0, ptr}, 8'h01);
        check("R10 flags visible", stat, 8'h03);
        cyc();
        check("R10 auto clear", stat, 8'h00);
        check("R10 ptr stable", {7'd0, ptr}, 8'h01);
        pulse(8'h01);
        cyc();
        check("R10 no toggle irq high", {7'd0, ptr}, 8'h01);
        check("R10 no auto clear without rise", stat, 8'h01);
        wr_iq(8'h01);
        pulse(8'h02);
        check("R10 second rise toggles", {7'd0, ptr}, 8'h00);
        hw_mode = 1'b0;
        wr_iq(8'h01);
        wr_cd(8'h00);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(); cyc();
        t_reset();
        rst_n = 1'b1; path_en = 1'b1;
        cyc();
        t_reset();
        t_sticky();
        t_irq_mask();
        t_sw_clear();
        t_cond_clear();
        t_disable();
        t_set_wins();
        t_timeout();
        t_hw();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule